// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets an on-chip requester read and write an external asynchronous static RAM of 512K locations by 8 bits. The requester presents a request through a valid/ready handshake. A request carries a 19-bit address, a write flag and 8-bit write data. A read completes with the captured byte and a one-cycle valid strobe.

On the memory side the controller drives active-low select, write and output-enable strobes, the address bus and a split data bus (out, in, drive enable). It sequences every access in whole clock cycles sized for a 100 MHz clock:

- A read keeps select and output enable low for a fixed number of cycles.
- A write is controlled by the write strobe. The strobe stays low across a first cycle in which the data bus is not driven, then across one or more cycles in which it is driven.
- After the write strobe rises, a hold cycle keeps address and data. A turnaround cycle follows before the next request can be accepted.

The data bus is never driven while the memory's outputs may be on.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, mem_ce_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0, rd_valid is 0 and req_ready is 1.
- R2: req_ready is 1 only while the controller is idle. While it is 1, all three memory strobes are high and the data bus is not driven. A request is taken on a rising edge where req_valid and req_ready are both 1.
- R3: For a read (req_write=0) taken at edge E, mem_ce_n and mem_oe_n are 0 and mem_we_n is 1 for the RD_CYC (default 2) cycles after E. mem_addr equals req_addr in those cycles.
- R4: At edge E+RD_CYC the read captures mem_din. rd_data then holds that byte and rd_valid is 1 for exactly one cycle. Strobes return high and req_ready returns to 1 in that same cycle.
- R5: For a write (req_write=1) taken at edge E, mem_ce_n and mem_we_n are 0 for the WR_CYC (default 2) cycles after E. mem_addr carries the request address from the first of those cycles.
- R6: mem_dq_oe is 0 in the first write-strobe-low cycle and 1, with mem_dout equal to req_wdata, in the remaining ones. mem_dq_oe falls in the same cycle that mem_we_n rises.
- R7: After mem_we_n rises, one hold cycle keeps mem_ce_n low with mem_addr and mem_dout unchanged. It is followed by TURN_CYC (default 1) cycles with all strobes high and req_ready 0; req_ready then returns to 1.
- R8: mem_dq_oe is 1 only when mem_oe_n is 1 in that cycle and was 1 in the cycle before. Hence a read after a write never sees the bus driven by the controller.
- R9: mem_we_n is low only while mem_ce_n is low, and mem_oe_n is never low while mem_we_n is low.
- R10: mem_addr does not change in any cycle where mem_ce_n is low in that cycle and the one before.
- R11: A write never produces an rd_valid pulse, and data written to an address is returned by a later read of it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Request address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle strobe, rd_data valid |
| rd_data | output | 8 | Captured read byte |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 19 | Memory address bus |
| mem_dout | output | 8 | Data toward the memory |
| mem_din | input | 8 | Data from the memory |
| mem_dq_oe | output | 1 | Controller drives the data bus |

## Verification
Every memory-side output is a register loaded from the next state, so each change appears a whole cycle after the edge that decides it. The accept edge is followed by:

| Access | Cycle after accept | Expected at the outputs |
|--------|--------------------|-------------------------|
| Read | first two | select and output enable low |
| Read | third | data valid, ready high |
| Write | first | write strobe low, bus undriven |
| Write | second | bus driven |
| Write | third | hold |
| Write | fourth | turnaround |
| Write | fifth | ready high |

Each task drives its request half a cycle before an edge and then samples on falling edges, one falling edge per cycle. Every cycle of the access is compared with this table. A bench memory model writes only in cycles where select, write strobe and drive are all active, and it flags any cycle where both sides could drive the bus.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSET,
    ST_WDRV,
    ST_WHLD,
    ST_TURN
  } state_t;
endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC   = 2,
  parameter int WR_CYC   = 2,
  parameter int HOLD_CYC = 1,
  parameter int TURN_CYC = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic accept,
  output logic capture,
  output logic ce_n,
  output logic we_n,
  output logic oe_n,
  output logic dq_oe
);
  localparam int MAX_A = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int MAX_B = (HOLD_CYC > TURN_CYC) ? HOLD_CYC : TURN_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = (MAX_C > 1) ? $clog2(MAX_C) : 1;

  state_t state, nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign capture   = (state == ST_READ) && (cnt == CNT_W'(RD_CYC - 1));

  always_comb begin
    nxt     = state;
    cnt_nxt = cnt + 1'b1;
    unique case (state)
      ST_IDLE: begin
        cnt_nxt = '0;
        if (req_valid) nxt = req_write ? ST_WSET : ST_READ;
      end
      ST_READ: if (cnt == CNT_W'(RD_CYC - 1)) nxt = ST_IDLE;
      ST_WSET: begin
        nxt     = ST_WDRV;
        cnt_nxt = '0;
      end
      ST_WDRV: if (cnt == CNT_W'(WR_CYC - 2)) begin
        nxt     = ST_WHLD;
        cnt_nxt = '0;
      end
      ST_WHLD: if (cnt == CNT_W'(HOLD_CYC - 1)) begin
        nxt     = ST_TURN;
        cnt_nxt = '0;
      end
      ST_TURN: if (cnt == CNT_W'(TURN_CYC - 1)) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      ce_n  <= 1'b1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      state <= nxt;
      cnt   <= cnt_nxt;
      ce_n  <= (nxt == ST_IDLE) || (nxt == ST_TURN);
      we_n  <= !((nxt == ST_WSET) || (nxt == ST_WDRV));
      oe_n  <= (nxt != ST_READ);
      dq_oe <= (nxt == ST_WDRV);
    end
  end
endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_din,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      mem_dout <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= capture;
      if (accept) begin
        mem_addr <= req_addr;
        mem_dout <= req_wdata;
      end
      if (capture) rd_data <= mem_din;
    end
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 8,
  parameter int RD_CYC   = 2,
  parameter int WR_CYC   = 2,
  parameter int HOLD_CYC = 1,
  parameter int TURN_CYC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  input  logic [DATA_W-1:0] mem_din,
  output logic              mem_dq_oe
);
  logic accept, capture;

  sram_ctrl_fsm #(
    .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .HOLD_CYC(HOLD_CYC), .TURN_CYC(TURN_CYC)
  ) u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_ready(req_ready), .accept(accept), .capture(capture),
    .ce_n(mem_ce_n), .we_n(mem_we_n), .oe_n(mem_oe_n), .dq_oe(mem_dq_oe)
  );

  sram_ctrl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .accept(accept), .capture(capture),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_din(mem_din),
    .mem_addr(mem_addr), .mem_dout(mem_dout),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rd_valid,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr
);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  assert_rd_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  assert_drive_in_write_R6: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> !mem_we_n);

  assert_hold_after_we_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (!mem_ce_n && !mem_dq_oe));

  assert_no_contention_R8: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (mem_oe_n && $past(mem_oe_n)));

  assert_we_needs_ce_R9: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));

  assert_addr_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));
endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rd_valid(rd_valid),
  .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_dq_oe(mem_dq_oe), .mem_addr(mem_addr)
);

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr  = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rd_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] rd_data, mem_dout, mem_din;
  logic [AW-1:0] mem_addr;

  int n_chk  = 0;
  int n_fail = 0;
  int n_contend = 0;
  bit done = 1'b0;
  logic [DW-1:0] mem [0:255];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_ctrl u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
    .mem_dout(mem_dout), .mem_din(mem_din), .mem_dq_oe(mem_dq_oe)
  );

  // memory model: drives when selected for reading, writes when strobed and driven
  assign mem_din = (!mem_ce_n && !mem_oe_n && mem_we_n) ? mem[mem_addr[7:0]] : 8'hEE;

  always @(negedge clk) begin
    if (!rst && !mem_ce_n && !mem_we_n && mem_dq_oe) mem[mem_addr[7:0]] <= mem_dout;
    if (!rst && mem_dq_oe && !mem_ce_n && !mem_oe_n) n_contend++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R1 strobes in reset", {mem_ce_n, mem_we_n, mem_oe_n}, 7);
    chk(!mem_dq_oe && !rd_valid, "R1 no drive/valid in reset", {mem_dq_oe, rd_valid}, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(req_ready, "R1 ready after reset", req_ready, 1);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 idle outputs",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 14);
  endtask

  task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
    chk(!mem_ce_n && !mem_we_n && mem_oe_n, "R5 first write cycle strobes",
        {mem_ce_n, mem_we_n, mem_oe_n}, 1);
    chk(mem_addr == a, "R5 write address", mem_addr, a);
    chk(!mem_dq_oe, "R6 bus undriven in first cycle", mem_dq_oe, 0);
    chk(!req_ready, "R2 busy during write", req_ready, 0);
    @(negedge clk);
    chk(!mem_ce_n && !mem_we_n && mem_dq_oe, "R6 driven second cycle",
        {mem_ce_n, mem_we_n, mem_dq_oe}, 1);
    chk(mem_dout == d, "R6 write data", mem_dout, d);
    @(negedge clk);
    chk(mem_we_n && !mem_dq_oe && !mem_ce_n, "R7 hold cycle", {mem_ce_n, mem_we_n, mem_dq_oe}, 2);
    chk(mem_addr == a && mem_dout == d, "R7 hold addr/data", mem_dout, d);
    @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !req_ready, "R7 turnaround",
        {mem_ce_n, mem_we_n, mem_oe_n, req_ready}, 14);
    chk(!rd_valid, "R11 no valid from write", rd_valid, 0);
    @(negedge clk);
    chk(req_ready, "R7 ready after turnaround", req_ready, 1);
  endtask

  task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] e);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = 8'h00;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a;
    for (int i = 0; i < 2; i++) begin
      chk(!mem_ce_n && !mem_oe_n && mem_we_n && !mem_dq_oe, "R3 read strobes",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 2);
      chk(mem_addr == a, "R3 read address", mem_addr, a);
      chk(!rd_valid && !req_ready, "R4 no early valid", {rd_valid, req_ready}, 0);
      @(negedge clk);
    end
    chk(rd_valid, "R4 valid strobe", rd_valid, 1);
    chk(rd_data == e, "R11 read data", rd_data, e);
    chk(mem_ce_n && mem_oe_n && req_ready, "R4 release on capture",
        {mem_ce_n, mem_oe_n, req_ready}, 7);
    @(negedge clk);
    chk(!rd_valid, "R4 single-cycle valid", rd_valid, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    @(negedge clk); @(negedge clk);
    t_reset();
    t_read(19'h00010, 8'h10 ^ 8'h5A);
    t_write(19'h00000, 8'hA5);
    t_read(19'h00000, 8'hA5);
    t_write(19'h7FFFF, 8'h3C);
    t_write(19'h12345, 8'hFF);
    t_read(19'h7FFFF, 8'h3C);
    t_read(19'h12345, 8'hFF);
    t_write(19'h00080, 8'h00);
    t_read(19'h00080, 8'h00);
    t_read(19'h00081, 8'h81 ^ 8'h5A);
    chk(n_contend == 0, "R8 bus contention cycles", n_contend, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule